// File: doc/BRIEF.md
# Fast Interrupt Mask Controller

This block keeps the two interrupt mask bits of a processor status register, one for the fast interrupt and one for the normal interrupt. It decides in each cycle whether a fast or a normal interrupt is taken. The fast request arrives on an active-low line from outside the clock domain. It passes through a synchronizer before it is evaluated, and a request that stays low remains pending until it is taken. The normal request is active high and has lower priority than the fast request.

The masks change in four ways: software writes, a restore path used on return from an exception, fast-exception entry and reset-exception entry. Fast entry masks both interrupt classes. A static configuration input selects a non-maskable mode. In that mode software and the restore path can clear the fast mask but can never set it, so once the reset handler clears the mask, fast interrupts reach the core at once. A read-only status bit reports the mode.

Top module: `fint_mask_ctrl`

## Requirements
- R1: While `rst_n` is low, both `fmask` and `nmask` read 1 and neither `take_fast` nor `take_norm` is asserted.
- R2: A cycle with `rst_entry` high sets both masks to 1 at the next clock edge. This wins over a fast entry, a restore or a software write in the same cycle.
- R3: A cycle with `fast_entry` high and `rst_entry` low sets both masks to 1 at the next edge. This wins over a restore or a software write in the same cycle.
- R4: `nm_status` equals `nm_cfg` at all times. A value of 0 means software may mask fast interrupts, and 1 means it may not.
- R5: With `nm_cfg` low, a software write (`sw_wr_en`) loads `sw_fmask` into `fmask` and `sw_nmask` into `nmask` at the next edge. Writing 1 to `fmask` masks fast interrupts.
- R6: With `nm_cfg` high, a software write of 0 to the fast mask clears it and a write of 1 leaves it unchanged. `nmask` is still loaded from `sw_nmask`. Without a fast or reset entry, `fmask` never goes from 0 to 1.
- R7: A restore (`rst_en_restore`) loads `rs_fmask`/`rs_nmask` under the same mode rule as a software write. It wins over a software write in the same cycle.
- R8: `take_fast` is high exactly when the fast request line, sampled through two flops, is low and `fmask` is 0. A line driven low before clock edge k produces `take_fast` after edge k+1, and a line held low stays pending.
- R9: `take_norm` is high exactly when `norm_req` is high, `nmask` is 0 and `take_fast` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_req_n | input | 1 | Fast interrupt request, active low, asynchronous |
| norm_req | input | 1 | Normal interrupt request, active high |
| nm_cfg | input | 1 | Static non-maskable fast interrupt mode select, active high |
| sw_wr_en | input | 1 | Software write strobe for the mask bits |
| sw_fmask | input | 1 | Fast mask value written by software |
| sw_nmask | input | 1 | Normal mask value written by software |
| fast_entry | input | 1 | Fast exception entry strobe |
| rst_entry | input | 1 | Reset exception entry strobe |
| rst_en_restore | input | 1 | Return-from-exception restore strobe |
| rs_fmask | input | 1 | Saved fast mask value to restore |
| rs_nmask | input | 1 | Saved normal mask value to restore |
| fmask | output | 1 | Current fast interrupt mask |
| nmask | output | 1 | Current normal interrupt mask |
| take_fast | output | 1 | Fast interrupt taken this cycle |
| take_norm | output | 1 | Normal interrupt taken this cycle |
| nm_status | output | 1 | Read-only non-maskable mode indication |

## Verification
A wrong mask state shows on `fmask`/`nmask` in the cycle right after the offending edge. It also shows on `take_fast` or `take_norm` as soon as a request is present. A synchronizer fault shows as `take_fast` rising one cycle early or late relative to the request line. The sharpest case is a set-write that gets through in non-maskable mode. That error stays hidden until a fast request arrives and `take_fast` fails to assert, so the bench checks the mask outputs every cycle rather than only the take outputs.

// File: rtl/fim_pkg.sv
package fim_pkg;

  typedef struct packed {
    logic f;  // fast mask
    logic n;  // normal mask
  } mask_t;

  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_SW,
    SRC_RESTORE,
    SRC_FAST,
    SRC_RESET
  } upd_src_e;

  localparam mask_t MASK_ALL = '{f: 1'b1, n: 1'b1};

  // Apply a write of new mask values under the mode rule.
  function automatic mask_t apply_write(mask_t cur, mask_t val, logic nm_on);
    mask_t r;
    r.n = val.n;
    r.f = nm_on ? (cur.f & val.f) : val.f;
    return r;
  endfunction

endpackage

// File: rtl/fim_sync.sv
module fim_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fim_mask_reg.sv
module fim_mask_reg
  import fim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  nm_on,
  input  logic  rst_entry,
  input  logic  fast_entry,
  input  logic  restore_en,
  input  mask_t restore_val,
  input  logic  sw_en,
  input  mask_t sw_val,
  output mask_t mask_q
);
  upd_src_e src;
  mask_t    mask_d;
  logic     mask_en;

  always_comb begin
    if (rst_entry)       src = SRC_RESET;
    else if (fast_entry) src = SRC_FAST;
    else if (restore_en) src = SRC_RESTORE;
    else if (sw_en)      src = SRC_SW;
    else                 src = SRC_HOLD;
  end

  always_comb begin
    mask_en = 1'b1;
    mask_d  = mask_q;
    unique case (src)
      SRC_RESET,
      SRC_FAST:    mask_d = MASK_ALL;
      SRC_RESTORE: mask_d = apply_write(mask_q, restore_val, nm_on);
      SRC_SW:      mask_d = apply_write(mask_q, sw_val, nm_on);
      default:     mask_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_ALL;
    else if (mask_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/fim_take.sv
module fim_take (
  input  logic fast_pending,
  input  logic norm_req,
  input  logic fmask,
  input  logic nmask,
  output logic take_fast,
  output logic take_norm
);
  always_comb begin
    take_fast = fast_pending & ~fmask;
    take_norm = norm_req & ~nmask & ~take_fast;
  end
endmodule

// File: rtl/fint_mask_ctrl.sv
module fint_mask_ctrl
  import fim_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_req_n,
  input  logic norm_req,
  input  logic nm_cfg,
  input  logic sw_wr_en,
  input  logic sw_fmask,
  input  logic sw_nmask,
  input  logic fast_entry,
  input  logic rst_entry,
  input  logic rst_en_restore,
  input  logic rs_fmask,
  input  logic rs_nmask,
  output logic fmask,
  output logic nmask,
  output logic take_fast,
  output logic take_norm,
  output logic nm_status
);
  logic  req_n_sync;
  mask_t mask_q;
  mask_t sw_val;
  mask_t rs_val;

  assign sw_val = '{f: sw_fmask, n: sw_nmask};
  assign rs_val = '{f: rs_fmask, n: rs_nmask};

  fim_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (fast_req_n),
    .q     (req_n_sync)
  );

  fim_mask_reg u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .nm_on       (nm_cfg),
    .rst_entry   (rst_entry),
    .fast_entry  (fast_entry),
    .restore_en  (rst_en_restore),
    .restore_val (rs_val),
    .sw_en       (sw_wr_en),
    .sw_val      (sw_val),
    .mask_q      (mask_q)
  );

  fim_take u_take (
    .fast_pending (~req_n_sync),
    .norm_req     (norm_req),
    .fmask        (mask_q.f),
    .nmask        (mask_q.n),
    .take_fast    (take_fast),
    .take_norm    (take_norm)
  );

  assign fmask     = mask_q.f;
  assign nmask     = mask_q.n;
  assign nm_status = nm_cfg;
endmodule

// File: rtl/fint_mask_ctrl_chk.sv
module fint_mask_ctrl_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic fast_req_n,
  input logic norm_req,
  input logic nm_cfg,
  input logic fast_entry,
  input logic rst_entry,
  input logic fmask,
  input logic nmask,
  input logic take_fast,
  input logic take_norm
);
  logic [3:0] age_q;
  logic [3:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q     <= '0;
      low_run_q <= '0;
    end else begin
      if (age_q != 4'hF) age_q <= age_q + 4'd1;
      if (fast_req_n)             low_run_q <= '0;
      else if (low_run_q != 4'hF) low_run_q <= low_run_q + 4'd1;
    end
  end

  // R2
  rst_entry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_entry |=> (fmask && nmask));

  // R3
  fast_entry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_entry |=> (fmask && nmask));

  // R6
  nm_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nm_cfg && !fmask && !fast_entry && !rst_entry) |=> !fmask);

  // R8
  held_req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run_q >= 4'(SYNC_STAGES) && age_q >= 4'(SYNC_STAGES) && !fmask) |-> take_fast);

  // R9
  takes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_fast && take_norm));

  // R9
  norm_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_norm |-> (norm_req && !nmask));
endmodule

bind fint_mask_ctrl fint_mask_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fast_req_n (fast_req_n),
  .norm_req   (norm_req),
  .nm_cfg     (nm_cfg),
  .fast_entry (fast_entry),
  .rst_entry  (rst_entry),
  .fmask      (fmask),
  .nmask      (nmask),
  .take_fast  (take_fast),
  .take_norm  (take_norm)
);

// File: tb/fint_mask_ctrl_bench.sv
module fint_mask_ctrl_bench;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst_n;
  logic fast_req_n, norm_req, nm_cfg;
  logic sw_wr_en, sw_fmask, sw_nmask;
  logic fast_entry, rst_entry;
  logic rst_en_restore, rs_fmask, rs_nmask;
  logic fmask, nmask, take_fast, take_norm, nm_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model state
  logic m_f, m_n, m_s1, m_s2;

  always #(HALF) clk = ~clk;

  fint_mask_ctrl u_fint_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .fast_req_n(fast_req_n), .norm_req(norm_req),
    .nm_cfg(nm_cfg), .sw_wr_en(sw_wr_en), .sw_fmask(sw_fmask), .sw_nmask(sw_nmask),
    .fast_entry(fast_entry), .rst_entry(rst_entry), .rst_en_restore(rst_en_restore),
    .rs_fmask(rs_fmask), .rs_nmask(rs_nmask), .fmask(fmask), .nmask(nmask),
    .take_fast(take_fast), .take_norm(take_norm), .nm_status(nm_status)
  );

  task automatic check(string req, logic act, logic exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_take_fast();
    return ~m_s2 & ~m_f;
  endfunction

  function automatic logic exp_take_norm();
    return norm_req & ~m_n & ~exp_take_fast();
  endfunction

  // Compute next mask from requirements R2, R3, R5, R6, R7
  function automatic logic [1:0] exp_next();
    logic wf, wn;
    if (rst_entry || fast_entry) return 2'b11;
    if (rst_en_restore) begin wf = rs_fmask; wn = rs_nmask; end
    else if (sw_wr_en)  begin wf = sw_fmask; wn = sw_nmask; end
    else return {m_f, m_n};
    return {nm_cfg ? (m_f & wf) : wf, wn};
  endfunction

  // Inputs are already driven; check outputs, then advance one clock.
  task automatic step(string req);
    logic [1:0] nx;
    #1;
    check(req, fmask, m_f, "fmask");
    check(req, nmask, m_n, "nmask");
    check("R8", take_fast, exp_take_fast(), "take_fast");
    check("R9", take_norm, exp_take_norm(), "take_norm");
    check("R4", nm_status, nm_cfg, "nm_status");
    nx = exp_next();
    @(posedge clk);
    m_f  = nx[1];
    m_n  = nx[0];
    m_s2 = m_s1;
    m_s1 = fast_req_n;
    @(negedge clk);
  endtask

  task automatic idle();
    sw_wr_en = 0; fast_entry = 0; rst_entry = 0; rst_en_restore = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; fast_req_n = 0; norm_req = 1; nm_cfg = 0;
    sw_fmask = 0; sw_nmask = 0; rs_fmask = 0; rs_nmask = 0;
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held, with requests active
    check("R1", fmask, 1'b1, "fmask in reset");
    check("R1", nmask, 1'b1, "nmask in reset");
    check("R1", take_fast, 1'b0, "take_fast in reset");
    check("R1", take_norm, 1'b0, "take_norm in reset");
    fast_req_n = 1; norm_req = 0;
    rst_n = 1;
    m_f = 1; m_n = 1; m_s1 = 1; m_s2 = 1;
    @(negedge clk);

    // R5 maskable mode: clear both, then set fast mask by software
    sw_wr_en = 1; sw_fmask = 0; sw_nmask = 0; step("R5");
    idle(); step("R5");
    check("R5", fmask, 1'b0, "fmask cleared");
    sw_wr_en = 1; sw_fmask = 1; sw_nmask = 0; step("R5");
    idle(); step("R5");
    check("R5", fmask, 1'b1, "fmask set by sw");

    // R8 sync latency: request low, fmask cleared
    sw_wr_en = 1; sw_fmask = 0; step("R5");
    idle(); fast_req_n = 0; step("R8");
    check("R8", take_fast, 1'b0, "one edge after request");
    step("R8");
    check("R8", take_fast, 1'b1, "two edges after request");
    fast_req_n = 1; norm_req = 1; step("R9"); step("R9"); step("R9");
    check("R9", take_norm, 1'b1, "normal taken");
    norm_req = 0;

    // R6 non-maskable mode: set-write ignored, clear honoured
    nm_cfg = 1;
    sw_wr_en = 1; sw_fmask = 1; sw_nmask = 1; step("R6");
    idle(); step("R6");
    check("R6", fmask, 1'b0, "set-write ignored");
    check("R6", nmask, 1'b1, "nmask still written");
    // R7 restore cannot set fast mask in nm mode; wins over sw write
    rst_en_restore = 1; rs_fmask = 1; rs_nmask = 0;
    sw_wr_en = 1; sw_fmask = 0; sw_nmask = 1; step("R7");
    idle(); step("R7");
    check("R7", fmask, 1'b0, "restore set ignored");
    check("R7", nmask, 1'b0, "restore beats sw");
    // R3 fast entry sets both, beats restore
    fast_entry = 1; rst_en_restore = 1; rs_fmask = 0; rs_nmask = 0; step("R3");
    idle(); step("R3");
    check("R3", fmask, 1'b1, "fast entry fmask");
    check("R3", nmask, 1'b1, "fast entry nmask");
    sw_wr_en = 1; sw_fmask = 0; sw_nmask = 0; step("R6");
    // R2 reset entry beats a clearing sw write
    rst_entry = 1; sw_wr_en = 1; sw_fmask = 0; sw_nmask = 0; step("R2");
    idle(); step("R2");
    check("R2", fmask, 1'b1, "reset entry fmask");
    check("R2", nmask, 1'b1, "reset entry nmask");

    // Random mix in both modes
    for (int ph = 0; ph < 2; ph++) begin
      nm_cfg = ph[0];
      for (int i = 0; i < 1500; i++) begin
        rst_entry      = ($urandom % 40) == 0;
        fast_entry     = ($urandom % 16) == 0;
        rst_en_restore = ($urandom % 8) == 0;
        sw_wr_en       = ($urandom % 3) == 0;
        sw_fmask = $urandom; sw_nmask = $urandom;
        rs_fmask = $urandom; rs_nmask = $urandom;
        norm_req = $urandom;
        if (($urandom % 6) == 0) fast_req_n = ~fast_req_n;
        step(ph == 0 ? "R5 random" : "R6 random");
      end
    end

    done = 1'b1;
    report();
  end
endmodule